// File: doc/BRIEF.md
# Burst read latency controller

This block sequences the read side of a synchronous burst memory port. When the host starts a burst with the active-low address strobe, the controller captures the start address and holds the first data word back for a programmable number of clock cycles. Then it streams consecutive words from an internal read-only array, one per clock, until chip enable is withdrawn. A wait flag tells the host when data is not yet usable. A direct (asynchronous) read path gives the word at the presented address with no latency at all.

A small configuration register sets the initial latency and chooses whether words launch on the rising or the falling clock edge. The register is written through a plain write-enable and data port. The value captured when a burst begins governs that whole burst.

Top module: `burst_lat_ctrl`

## Requirements
- R1: After reset, dq_oe and wait_o are 0 and dq is 0. The latency code resets to 7 (9 cycles) and rising-edge launch is selected.
- R2: A configuration write whose bit 13 is 0 loads the code c from bits [12:10]. The latency is L = c + 2 cycles. The first word appears after the rising edge that comes L edges after the latch edge.
- R3: A configuration write with bit 13 set leaves the latency code unchanged. Bit 6 (edge select) is still updated.
- R4: A burst starts, and addr_in is captured, on the first rising edge that sees adv_n low while ce_n is low and rd_async is low. Holding adv_n low for further edges does not restart the burst.
- R5: If adv_n was sampled low on an edge without starting a burst (ce_n high), a later edge that sees adv_n high with ce_n low starts the burst. That edge captures addr_in as presented then.
- R6: wait_o is 1 from the latch edge up to edge L-1 after it, and 0 from edge L-1 on. It is never 1 while dq_oe is 1.
- R7: Burst words are word(A), word(A+1), … with one new word per rising edge. The address wraps modulo 256. word(a) is {a,a} XOR 0xA5C3 for 8-bit addresses and 16-bit data, i.e. the address pattern repeated across the word, XOR the pattern parameter.
- R8: With bit 6 = 1, words change just after rising edges. With bit 6 = 0, the cycle count is the same, but each word changes after the falling edge that follows that rising edge.
- R9: ce_n high forces dq_oe and wait_o to 0 at once, without waiting for a clock, and ends the burst. With ce_n low again, no data appears until a new strobe.
- R10: With rd_async high and ce_n low, dq equals word(addr_in) without waiting for a clock. In that state dq_oe is 1 and wait_o is 0, whatever latency is programmed.
- R11: A configuration write during a burst does not alter that burst. The new value applies from the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; high aborts a burst |
| adv_n | input | 1 | Active-low address strobe |
| rd_async | input | 1 | Direct read select, bypasses latency |
| addr_in | input | ADDR_W | Start / direct read address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | CFG_W | Configuration write data |
| dq | output | DATA_W | Read data, 0 when not driven |
| dq_oe | output | 1 | Data output enable for the pad |
| wait_o | output | 1 | High while burst data is not yet valid |

## Verification
The bench builds the block with its default parameters. The 3-bit latency code reaches every latency from 2 to 9 cycles, and both launch edges are exercised. The 8-bit address lets a burst started near the top of the array wrap to address 0 within a few words. With the default bit positions, the reserved-code flag and edge select sit where the bench writes them, so ignored writes and mid-burst writes can be observed at the data pins.

// File: rtl/blc_pkg.sv
package blc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_STREAM = 2'd2
   } blc_state_e;
endpackage

// File: rtl/blc_cfg_reg.sv
module blc_cfg_reg #(
   parameter int CFG_W    = 16,
   parameter int CODE_W   = 3,
   parameter int LAT_LSB  = 10,
   parameter int EDGE_BIT = 6,
   parameter int RST_CODE = 7,
   parameter bit RST_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   output logic [CODE_W-1:0] code_q,
   output logic              edge_q
);
   localparam int RSV_BIT = LAT_LSB + CODE_W;

   logic              rsv;
   logic [CODE_W-1:0] new_code;
   logic              unused_cfg_bits;

   assign rsv             = wdata[RSV_BIT];
   assign new_code        = wdata[LAT_LSB +: CODE_W];
   assign unused_cfg_bits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_W'(RST_CODE);
         edge_q <= RST_EDGE;
      end else if (we) begin
         edge_q <= wdata[EDGE_BIT];
         if (!rsv) code_q <= new_code;
      end
   end

   assert_rsv_keeps_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[RSV_BIT]) |=> (code_q == $past(code_q)));

   assert_edge_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (edge_q == $past(wdata[EDGE_BIT])));
endmodule

// File: rtl/blc_start_det.sv
module blc_start_det (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic adv_n,
   input  logic rd_async,
   output logic start
);
   logic prev_low;
   logic taken;
   logic low_hit;
   logic rise_hit;

   assign low_hit  = !adv_n && !taken;
   assign rise_hit = adv_n && prev_low && !taken;
   assign start    = !ce_n && !rd_async && (low_hit || rise_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_low <= 1'b0;
         taken    <= 1'b0;
      end else begin
         prev_low <= !adv_n;
         taken    <= adv_n ? 1'b0 : (taken || start);
      end
   end

   assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !adv_n) |=> !start);

   assert_start_needs_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!ce_n && !rd_async));
endmodule

// File: rtl/blc_array.sv
module blc_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] PAT = 16'hA5C3
) (
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [ADDR_W-1:0] addr_a,
   output logic [DATA_W-1:0] word_b,
   output logic [DATA_W-1:0] word_a
);
   localparam int DEPTH = 1 << ADDR_W;

   function automatic logic [DATA_W-1:0] fill(input logic [ADDR_W-1:0] a);
      logic [DATA_W-1:0] w;
      for (int b = 0; b < DATA_W; b++) w[b] = a[b % ADDR_W];
      return w ^ PAT;
   endfunction

   logic [DATA_W-1:0] rom [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign rom[i] = fill(ADDR_W'(i));
   end

   assign word_b = rom[addr_b];
   assign word_a = rom[addr_a];
endmodule

// File: rtl/blc_seq.sv
module blc_seq
   import blc_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int CODE_W   = 3,
   parameter int LAT_BASE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [CODE_W-1:0] code_q,
   input  logic              edge_q,
   input  logic [DATA_W-1:0] word_b,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] dq_q,
   output logic              oe_q,
   output logic              wait_q,
   output logic              edge_b
);
   localparam int MAX_LAT = (1 << CODE_W) - 1 + LAT_BASE;
   localparam int CNT_W   = $clog2(MAX_LAT + 1);

   blc_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_q;

   assign rd_addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         addr_q <= '0;
         dq_q   <= '0;
         oe_q   <= 1'b0;
         wait_q <= 1'b0;
         edge_b <= 1'b1;
      end else if (abort) begin
         state  <= ST_IDLE;
         oe_q   <= 1'b0;
         wait_q <= 1'b0;
      end else if (start) begin
         state  <= ST_WAIT;
         cnt    <= CNT_W'(code_q) + CNT_W'(LAT_BASE);
         addr_q <= addr_in;
         edge_b <= edge_q;
         oe_q   <= 1'b0;
         wait_q <= 1'b1;
      end else begin
         case (state)
            ST_WAIT: begin
               cnt <= cnt - CNT_W'(1);
               if (cnt == CNT_W'(2)) wait_q <= 1'b0;
               if (cnt == CNT_W'(1)) begin
                  state  <= ST_STREAM;
                  dq_q   <= word_b;
                  addr_q <= addr_q + ADDR_W'(1);
                  oe_q   <= 1'b1;
                  wait_q <= 1'b0;
               end
            end
            ST_STREAM: begin
               dq_q   <= word_b;
               addr_q <= addr_q + ADDR_W'(1);
            end
            default: begin
               oe_q   <= 1'b0;
               wait_q <= 1'b0;
            end
         endcase
      end
   end

   assert_wait_data_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wait_q && oe_q));

   assert_wait_after_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !abort) |=> wait_q);

   assert_cnt_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (cnt != '0 && cnt <= CNT_W'(MAX_LAT)));

   assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STREAM && !abort && !start) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

   assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && !start && !abort) |=> $stable(edge_b));
endmodule

// File: rtl/blc_launch.sv
module blc_launch #(
   parameter int DATA_W  = 16,
   parameter bit FALL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] dq_pos,
   input  logic              oe_pos,
   input  logic              edge_b,
   output logic [DATA_W-1:0] dq_out,
   output logic              oe_out
);
   if (FALL_EN) begin : g_fall
      logic [DATA_W-1:0] dq_neg;
      logic              oe_neg;

      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dq_neg <= '0;
            oe_neg <= 1'b0;
         end else begin
            dq_neg <= dq_pos;
            oe_neg <= oe_pos;
         end
      end

      assign dq_out = edge_b ? dq_pos : dq_neg;
      assign oe_out = edge_b ? oe_pos : oe_neg;

      assert_half_cycle_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (oe_neg == oe_pos) && (dq_neg == dq_pos));
   end else begin : g_rise
      logic unused_edge;
      assign unused_edge = edge_b;
      assign dq_out      = dq_pos;
      assign oe_out      = oe_pos;
   end
endmodule

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int CFG_W    = 16,
   parameter int CODE_W   = 3,
   parameter int LAT_BASE = 2,
   parameter int LAT_LSB  = 10,
   parameter int EDGE_BIT = 6,
   parameter int RST_CODE = 7,
   parameter bit FALL_EN  = 1'b1,
   parameter logic [DATA_W-1:0] PAT = 16'hA5C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              adv_n,
   input  logic              rd_async,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [DATA_W-1:0] dq,
   output logic              dq_oe,
   output logic              wait_o
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 1..12");
   end
   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("CODE_W must lie in 1..4");
   end
   if (LAT_BASE < 2) begin : g_bad_base
      $error("LAT_BASE must be at least 2");
   end
   if (LAT_LSB + CODE_W >= CFG_W) begin : g_bad_field
      $error("latency field and reserved flag must fit in CFG_W");
   end
   if (EDGE_BIT >= CFG_W || (EDGE_BIT >= LAT_LSB && EDGE_BIT <= LAT_LSB + CODE_W)) begin : g_bad_edge
      $error("EDGE_BIT must be inside CFG_W and clear of the latency field");
   end
   if (RST_CODE < 0 || RST_CODE >= (1 << CODE_W)) begin : g_bad_rst
      $error("RST_CODE must fit CODE_W");
   end

   logic [CODE_W-1:0] code_q;
   logic              edge_q;
   logic              start;
   logic              abort;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] word_b;
   logic [DATA_W-1:0] word_a;
   logic [DATA_W-1:0] dq_q;
   logic              oe_q;
   logic              wait_q;
   logic              edge_b;
   logic [DATA_W-1:0] dq_l;
   logic              oe_l;
   logic              async_sel;

   assign abort     = ce_n || rd_async;
   assign async_sel = !ce_n && rd_async;

   blc_cfg_reg #(
      .CFG_W(CFG_W), .CODE_W(CODE_W), .LAT_LSB(LAT_LSB),
      .EDGE_BIT(EDGE_BIT), .RST_CODE(RST_CODE), .RST_EDGE(1'b1)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .code_q(code_q), .edge_q(edge_q)
   );

   blc_start_det u_start (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n),
      .rd_async(rd_async), .start(start)
   );

   blc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT(PAT)) u_array (
      .addr_b(rd_addr), .addr_a(addr_in), .word_b(word_b), .word_a(word_a)
   );

   blc_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .LAT_BASE(LAT_BASE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .addr_in(addr_in), .code_q(code_q), .edge_q(edge_q), .word_b(word_b),
      .rd_addr(rd_addr), .dq_q(dq_q), .oe_q(oe_q), .wait_q(wait_q), .edge_b(edge_b)
   );

   blc_launch #(.DATA_W(DATA_W), .FALL_EN(FALL_EN)) u_launch (
      .clk(clk), .rst_n(rst_n), .dq_pos(dq_q), .oe_pos(oe_q),
      .edge_b(edge_b), .dq_out(dq_l), .oe_out(oe_l)
   );

   assign dq_oe  = !ce_n && (rd_async || oe_l);
   assign wait_o = !ce_n && !rd_async && wait_q;
   assign dq     = async_sel ? word_a : (dq_oe ? dq_l : '0);

   assert_ce_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n) |-> !oe_q);
endmodule

// File: tb/tb_burst_lat_ctrl.sv
`timescale 1ns/1ps
module tb_burst_lat_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        adv_n = 1'b1;
   logic        rd_async = 1'b0;
   logic [7:0]  addr_in = '0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] dq;
   logic        dq_oe;
   logic        wait_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   burst_lat_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .rd_async(rd_async),
      .addr_in(addr_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .dq(dq), .dq_oe(dq_oe), .wait_o(wait_o)
   );

   // code[14:12], edge[11], addr[7:0] (bit 8-10 unused)
   localparam logic [14:0] VEC [8] = '{
      {3'd0, 1'b1, 3'd0, 8'h10},
      {3'd1, 1'b0, 3'd0, 8'h20},
      {3'd3, 1'b1, 3'd0, 8'h33},
      {3'd5, 1'b0, 3'd0, 8'h7F},
      {3'd7, 1'b1, 3'd0, 8'hFE},
      {3'd2, 1'b0, 3'd0, 8'hC4},
      {3'd6, 1'b1, 3'd0, 8'h01},
      {3'd4, 1'b0, 3'd0, 8'hFF}
   };

   function automatic logic [15:0] wexp(input logic [7:0] a);
      return {a, a} ^ 16'hA5C3;
   endfunction

   function automatic logic [15:0] cfgv(input int code, input bit edge_sel);
      return (16'(code) << 10) | (16'(edge_sel) << 6);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp_v, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic start_burst(input logic [7:0] a, input bit do_cfg, input logic [15:0] cv);
      if (do_cfg) begin
         cfg_we    = 1'b1;
         cfg_wdata = cv;
         tick();
         cfg_we    = 1'b0;
      end
      ce_n     = 1'b0;
      rd_async = 1'b0;
      adv_n    = 1'b0;
      addr_in  = a;
      tick();
   endtask

   // Called right after the latch edge (posedge + 1 ns).
   task automatic observe(input int lat, input bit edge_sel, input logic [7:0] a,
                          input int nwords, input int hold, input bit mid,
                          input logic [15:0] midv);
      chk(wait_o == 1'b1 && dq_oe == 1'b0, "R6 wait at latch", {wait_o, dq_oe}, 2'b10);
      adv_n   = (hold > 1) ? 1'b0 : 1'b1;
      addr_in = (hold > 1) ? a : ~a;
      for (int j = 1; j < lat + nwords; j++) begin
         tick();
         if (j == lat)
            chk(dq_oe == edge_sel, "R8 early enable", dq_oe, edge_sel);
         if (edge_sel && j >= lat)
            chk(dq == wexp(a + 8'(j - lat)), "R8 rising launch data", dq, wexp(a + 8'(j - lat)));
         adv_n     = (j + 1 < hold) ? 1'b0 : 1'b1;
         addr_in   = (j + 1 < hold) ? a : ~a;
         cfg_we    = mid && (j == 1);
         cfg_wdata = midv;
         #5;
         chk(wait_o == (j < lat - 1), "R6 wait timing", wait_o, (j < lat - 1));
         chk(dq_oe == (j >= lat), "R2 first word timing", dq_oe, (j >= lat));
         if (j >= lat)
            chk(dq == wexp(a + 8'(j - lat)), "R7 burst word", dq, wexp(a + 8'(j - lat)));
      end
      cfg_we = 1'b0;
      ce_n   = 1'b1;
      #1;
      chk(dq_oe == 1'b0 && wait_o == 1'b0, "R9 abort quiet", {dq_oe, wait_o}, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      ce_n = 1'b0;
      #1;
      chk(dq_oe == 1'b0 && wait_o == 1'b0 && dq == 16'h0, "R1 reset outputs", {dq_oe, wait_o, dq}, 0);
      rst_n = 1'b1;
      ce_n  = 1'b1;
      tick();
      tick();
      chk(dq_oe == 1'b0 && wait_o == 1'b0, "R1 idle after reset", {dq_oe, wait_o}, 0);

      // R1: reset latency 9 cycles, rising launch
      start_burst(8'h05, 1'b0, 16'h0);
      observe(9, 1'b1, 8'h05, 2, 0, 1'b0, 16'h0);
      tick();

      // R2/R7/R8: vector table over all codes and both edges
      foreach (VEC[k]) begin
         start_burst(VEC[k][7:0], 1'b1, cfgv(int'(VEC[k][14:12]), VEC[k][11]));
         observe(int'(VEC[k][14:12]) + 2, VEC[k][11], VEC[k][7:0], 3, 0, 1'b0, 16'h0);
         tick();
      end

      // R3: reserved code leaves latency 5, edge bit still updated to falling
      cfg_we = 1'b1; cfg_wdata = cfgv(3, 1'b1); tick();
      cfg_wdata = 16'h2000 | cfgv(1, 1'b0); tick();
      cfg_we = 1'b0;
      start_burst(8'h61, 1'b0, 16'h0);
      observe(5, 1'b0, 8'h61, 2, 0, 1'b0, 16'h0);
      tick();

      // R4: strobe held low three edges, no restart
      start_burst(8'h40, 1'b1, cfgv(1, 1'b1));
      observe(3, 1'b1, 8'h40, 3, 3, 1'b0, 16'h0);
      tick();

      // R5: low sample with ce_n high, then rise with ce_n low latches
      cfg_we = 1'b1; cfg_wdata = cfgv(2, 1'b1); tick();
      cfg_we = 1'b0;
      ce_n = 1'b1; adv_n = 1'b0; addr_in = 8'h90; tick();
      ce_n = 1'b0; adv_n = 1'b1; addr_in = 8'h91; tick();
      observe(4, 1'b1, 8'h91, 2, 0, 1'b0, 16'h0);
      tick();

      // R11: write mid-burst, current burst keeps L=4 rising; next uses L=9 falling
      start_burst(8'h22, 1'b1, cfgv(2, 1'b1));
      observe(4, 1'b1, 8'h22, 2, 0, 1'b1, cfgv(7, 1'b0));
      tick();
      start_burst(8'h23, 1'b0, 16'h0);
      observe(9, 1'b0, 8'h23, 2, 0, 1'b0, 16'h0);
      tick();

      // R9: abort during latency, then no data without a new strobe
      start_burst(8'hA0, 1'b1, cfgv(0, 1'b1));
      adv_n = 1'b1;
      tick();
      ce_n = 1'b1;
      #1;
      chk(wait_o == 1'b0, "R9 wait drops at once", wait_o, 0);
      tick();
      ce_n = 1'b0;
      repeat (6) tick();
      chk(dq_oe == 1'b0 && wait_o == 1'b0, "R9 no data after abort", {dq_oe, wait_o}, 0);

      // R10: direct read ignores latency, follows address without a clock
      rd_async = 1'b1; addr_in = 8'h12;
      #1;
      chk(dq == wexp(8'h12) && dq_oe && !wait_o, "R10 direct read", dq, wexp(8'h12));
      addr_in = 8'hE7;
      #1;
      chk(dq == wexp(8'hE7), "R10 direct read follows address", dq, wexp(8'hE7));
      tick();
      chk(dq == wexp(8'hE7) && dq_oe && !wait_o, "R10 direct read steady", dq, wexp(8'hE7));
      rd_async = 1'b0; ce_n = 1'b1;
      tick();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule